// File: doc/BRIEF.md
# Serial-Programmed Dual-Word Divider Loader

This block is the digital control front end of a frequency synthesizer. A three-wire serial port (data, shift clock, frame enable) fills a 24-bit shift register. When the frame enable falls, the two lowest bits of the captured word pick its destination: one of two divider-setting buffers, or a control register. Each of the two divider buffers holds a main (M) count and a swallow (A) count for a dual-modulus counter model. The control register holds the reference divider ratio (R), a monitor-routing bit and a two-bit charge-pump current multiplier. The multiplier is only passed to an output pin.

A live select pin picks which divider buffer feeds the M/A counter. The counter takes the new setting only when a count cycle ends, so a cycle is never cut short or stretched by a write or a select change. The routing bit decides which of the two divider pulse trains appears on each of the two monitor pins. A power-down input stops both dividers. The serial port and the buffers keep working while it is high.

All serial pins are oversampled in the reference clock domain (`clk`). The serial clock must therefore stay in each level for several `clk` cycles.

Top module: `sdl_divider_loader`

## Requirements
- R1: On each rising edge of `ser_clk` while `ser_en` is high, the shift register shifts left and takes `ser_data` into bit 0, so words arrive MSB first. Edges of `ser_clk` while `ser_en` is low change nothing.
- R2: A falling edge of `ser_en` copies the shift register into the destination named by bits [1:0]: 2'b00 selects divider buffer one, 2'b01 selects divider buffer two, 2'b10 selects the control register. With 2'b11 the word is dropped and no register changes.
- R3: In a divider word, A is bits [8:2] and M is bits [18:9]. In a control word, R is bits [13:2], the routing bit is bit 14 and the current multiplier is bits [16:15]. `cp_mult` always shows the stored multiplier.
- R4: A frame that ends with fewer than 24 shift clocks still loads the shift register as it stands: the older bits move up and the new bits sit at the bottom.
- R5: A count cycle of the M/A counter lasts M*PRE + A `clk` cycles. Each completed count cycle gives one pulse that is high for exactly one cycle.
- R6: The active M/A pair is replaced only at the end of a count cycle. The new pair comes from buffer one when `f1_sel` is high and from buffer two when it is low, sampled at that end.
- R7: The reference divider gives a one-cycle pulse every R `clk` cycles.
- R8: A stored M, A or R value of zero behaves as one.
- R9: With the routing bit at 0, `mon1` carries the M/A pulses and `mon2` the reference pulses. With the bit at 1 the two are swapped.
- R10: While `pwr_dn` is high, both dividers stay at count zero and both monitor outputs stay low. Serial writes still reach the buffers.
- R11: The asynchronous active-low reset clears every buffer to zero. Right after reset, `cp_mult` is 0, the M/A period is PRE+1 and the reference pulse is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; it also clocks the divider model and the serial sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame enable; its falling edge loads the word |
| f1_sel | input | 1 | High picks divider buffer one, low picks buffer two |
| pwr_dn | input | 1 | Stops both dividers; the serial port stays active |
| mon1 | output | 1 | Monitor output one (M/A pulses when the routing bit is 0) |
| mon2 | output | 1 | Monitor output two (reference pulses when the routing bit is 0) |
| cp_mult | output | 2 | Stored charge-pump current multiplier |

## Verification
A stray bit or an error in address decoding shows on `cp_mult` within a few cycles of the frame end. It also shows as a wrong spacing between monitor pulses, within one period of the affected divider. An early reload of the active M/A pair is only visible in the period that straddles the change. The bench therefore flips the select pin right after a pulse and expects one more period of the old length before the new length appears. A power-down that fails to hold the counters shows as a pulse while `pwr_dn` is high. A broken routing bit shows as the two periods exchanged between the monitor pins.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    parameter int WORD_W  = 24;
    parameter int ADDR_W  = 2;
    parameter int M_W     = 10;
    parameter int A_W     = 7;
    parameter int R_W     = 12;
    parameter int CP_W    = 2;

    localparam int A_LSB     = ADDR_W;
    localparam int M_LSB     = A_LSB + A_W;
    localparam int R_LSB     = ADDR_W;
    localparam int SENSE_BIT = R_LSB + R_W;
    localparam int CP_LSB    = SENSE_BIT + 1;

    typedef enum logic [ADDR_W-1:0] {
        DEST_BUF1 = 2'b00,
        DEST_BUF2 = 2'b01,
        DEST_CTL  = 2'b10,
        DEST_NONE = 2'b11
    } dest_e;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } ma_word_t;

    typedef struct packed {
        logic            swap;
        logic [CP_W-1:0] cp;
        logic [R_W-1:0]  r;
    } ctl_word_t;

endpackage

// File: rtl/sdl_serial_rx.sv
module sdl_serial_rx #(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    output logic [WORD_W-1:0] word,
    output logic              load
);

    localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0]      sclk;
        logic [S-1:0]      sdat;
        logic [S-1:0]      sen;
        logic              sclk_last;
        logic              sen_last;
        logic [WORD_W-1:0] shift;
        logic              load;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      clk_s, en_s, dat_s;

    assign clk_s = st_q.sclk[S-1];
    assign en_s  = st_q.sen[S-1];
    assign dat_s = st_q.sdat[S-1];

    always_comb begin
        st_d           = st_q;
        st_d.sclk      = {st_q.sclk[S-2:0], ser_clk};
        st_d.sdat      = {st_q.sdat[S-2:0], ser_data};
        st_d.sen       = {st_q.sen[S-2:0], ser_en};
        st_d.sclk_last = clk_s;
        st_d.sen_last  = en_s;
        st_d.load      = st_q.sen_last & ~en_s;
        if (en_s && clk_s && !st_q.sclk_last) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], dat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.shift;
    assign load = st_q.load;

    // R1: with the synchronised enable low, the shift register must hold
    a_r1_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(st_q.shift));

endmodule

// File: rtl/sdl_regbank.sv
module sdl_regbank
    import sdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              load,
    output ma_word_t          buf1,
    output ma_word_t          buf2,
    output ctl_word_t         ctl
);

    typedef struct packed {
        ma_word_t  b1;
        ma_word_t  b2;
        ctl_word_t c;
    } bank_t;

    bank_t     bk_d, bk_q;
    dest_e     dest;
    ma_word_t  ma_new;
    ctl_word_t ctl_new;

    always_comb begin
        dest         = dest_e'(word[ADDR_W-1:0]);
        ma_new.m     = word[M_LSB +: M_W];
        ma_new.a     = word[A_LSB +: A_W];
        ctl_new.r    = word[R_LSB +: R_W];
        ctl_new.swap = word[SENSE_BIT];
        ctl_new.cp   = word[CP_LSB +: CP_W];

        bk_d = bk_q;
        if (load) begin
            unique case (dest)
                DEST_BUF1: bk_d.b1 = ma_new;
                DEST_BUF2: bk_d.b2 = ma_new;
                DEST_CTL:  bk_d.c  = ctl_new;
                default:   bk_d    = bk_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign buf1 = bk_q.b1;
    assign buf2 = bk_q.b2;
    assign ctl  = bk_q.c;

    // R2: a word with the reserved destination leaves every register untouched
    a_r2_reserved_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[ADDR_W-1:0] == 2'b11) |=> $stable(bk_q));

    // R2: no register moves without a load strobe
    a_r2_load_only: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bk_q));

endmodule

// File: rtl/sdl_ma_counter.sv
module sdl_ma_counter
    import sdl_pkg::*;
#(
    parameter int PRE = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     f1_sel,
    input  ma_word_t buf1,
    input  ma_word_t buf2,
    output logic     pulse
);

    localparam int CW = M_W + A_W + $clog2(PRE + 1);
    localparam logic [CW-1:0] PRE_C = CW'(PRE);

    typedef struct packed {
        logic [CW-1:0] cnt;
        ma_word_t      act;
        logic          pls;
    } ma_state_t;

    ma_state_t      st_d, st_q;
    logic [M_W-1:0] m_eff;
    logic [A_W-1:0] a_eff;
    logic [CW-1:0]  cyc_len;
    logic           wrap;

    always_comb begin
        m_eff   = (st_q.act.m == '0) ? M_W'(1) : st_q.act.m;
        a_eff   = (st_q.act.a == '0) ? A_W'(1) : st_q.act.a;
        cyc_len = CW'(m_eff) * PRE_C + CW'(a_eff);
        wrap    = (st_q.cnt >= cyc_len - CW'(1));

        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.pls = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.pls = 1'b1;
            st_d.act = f1_sel ? buf1 : buf2;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
            st_d.pls = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pls;

    // R6: the active pair only changes at the end of a count cycle
    a_r6_reload_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && wrap) |=> $stable(st_q.act));

    // R5: the cycle pulse lasts one clock
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pls |=> !st_q.pls);

    // R10: no pulse follows a powered-down cycle
    a_r10_ma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.pls && st_q.cnt == '0));

endmodule

// File: rtl/sdl_ref_div.sv
module sdl_ref_div
    import sdl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [R_W-1:0] ratio,
    output logic           pulse
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           pls;
    } rd_state_t;

    rd_state_t      st_d, st_q;
    logic [R_W-1:0] r_eff;
    logic           wrap;

    always_comb begin
        r_eff = (ratio == '0) ? R_W'(1) : ratio;
        wrap  = (st_q.cnt >= r_eff - R_W'(1));

        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.pls = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.pls = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + R_W'(1);
            st_d.pls = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pls;

    // R10: reference pulses stop while powered down
    a_r10_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !st_q.pls);

    // R7: with a ratio above one, a pulse is never followed at once by another
    a_r7_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pls && ratio > R_W'(1) && $stable(ratio)) |=> !st_q.pls);

endmodule

// File: rtl/sdl_divider_loader.sv
module sdl_divider_loader
    import sdl_pkg::*;
#(
    parameter int PRE         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_en,
    input  logic            f1_sel,
    input  logic            pwr_dn,
    output logic            mon1,
    output logic            mon2,
    output logic [CP_W-1:0] cp_mult
);

    logic [WORD_W-1:0] rx_word;
    logic              rx_load;
    ma_word_t          buf1, buf2;
    ctl_word_t         ctl;
    logic              run;
    logic              ma_pulse, ref_pulse;

    assign run = ~pwr_dn;

    sdl_serial_rx #(
        .WORD_W      (WORD_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_en   (ser_en),
        .word     (rx_word),
        .load     (rx_load)
    );

    sdl_regbank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .word  (rx_word),
        .load  (rx_load),
        .buf1  (buf1),
        .buf2  (buf2),
        .ctl   (ctl)
    );

    sdl_ma_counter #(
        .PRE (PRE)
    ) u_ma (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .f1_sel (f1_sel),
        .buf1   (buf1),
        .buf2   (buf2),
        .pulse  (ma_pulse)
    );

    sdl_ref_div u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ratio (ctl.r),
        .pulse (ref_pulse)
    );

    always_comb begin
        mon1 = ctl.swap ? ref_pulse : ma_pulse;
        mon2 = ctl.swap ? ma_pulse  : ref_pulse;
    end

    assign cp_mult = ctl.cp;

    // R10: both monitors are low one cycle into power-down
    a_r10_mon_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && $past(pwr_dn)) |-> (!mon1 && !mon2));

endmodule

// File: tb/sdl_divider_loader_bench.sv
module sdl_divider_loader_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_en = 1'b0;
    logic       f1_sel = 1'b1;
    logic       pwr_dn = 1'b0;
    logic       mon1, mon2;
    logic [1:0] cp_mult;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdl_divider_loader #(.PRE(4), .SYNC_STAGES(2)) u_sdl_divider_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_en   (ser_en),
        .f1_sel   (f1_sel),
        .pwr_dn   (pwr_dn),
        .mon1     (mon1),
        .mon2     (mon2),
        .cp_mult  (cp_mult)
    );

    typedef struct packed {
        logic [9:0] m;
        logic [6:0] a;
        logic [31:0] len;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{m: 10'd3, a: 7'd2, len: 32'd14},
        '{m: 10'd0, a: 7'd0, len: 32'd5},
        '{m: 10'd7, a: 7'd0, len: 32'd29},
        '{m: 10'd2, a: 7'd5, len: 32'd13}
    };

    function automatic logic [23:0] div_word(logic [9:0] m, logic [6:0] a, logic [1:0] dst);
        return {5'b0, m, a, dst};
    endfunction

    function automatic logic [23:0] ctl_word(logic [11:0] r, logic sw, logic [1:0] cp);
        return {7'b0, cp, sw, r, 2'b10};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        ser_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ser_en = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic pick(input int which);
        return (which == 1) ? mon1 : mon2;
    endfunction

    task automatic wait_pulse(input int which);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pick(which) && n < 5000);
    endtask

    task automatic count_next(input int which, output int per);
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!pick(which) && per < 5000);
    endtask

    task automatic measure(input int which, output int per);
        wait_pulse(which);
        count_next(which, per);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, per2, highs;
        logic [23:0] c_full, c_part;

        // R11: reset state
        repeat (3) @(negedge clk);
        check(cp_mult == 2'd0, "R11 cp_mult in reset", cp_mult, 0);
        rst_n = 1'b1;
        measure(1, per);
        check(per == 5, "R11/R8 M/A period after reset", per, 5);
        measure(2, per);
        check(per == 1, "R11/R8 reference period after reset", per, 1);

        // R3 / R7: control word
        send_bits(ctl_word(12'd6, 1'b0, 2'd1), 24);
        check(cp_mult == 2'd1, "R3 cp_mult from control word", cp_mult, 1);
        measure(2, per);
        check(per == 6, "R7 reference period R=6", per, 6);

        // R5 / R2 / R8: walk the vector table through buffer one
        f1_sel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            send_bits(div_word(VECS[k].m, VECS[k].a, 2'b00), 24);
            wait_pulse(1);
            wait_pulse(1);
            count_next(1, per);
            check(per == int'(VECS[k].len), "R5 M/A period from table", per, int'(VECS[k].len));
        end

        // R6: reload only at the cycle boundary
        send_bits(div_word(10'd3, 7'd2, 2'b00), 24);
        send_bits(div_word(10'd5, 7'd1, 2'b01), 24);
        wait_pulse(1);
        wait_pulse(1);
        f1_sel = 1'b0;
        count_next(1, per);
        check(per == 14, "R6 period straddling select change", per, 14);
        count_next(1, per2);
        check(per2 == 21, "R6 period after boundary reload", per2, 21);

        // R9: routing swap
        send_bits(ctl_word(12'd6, 1'b1, 2'd2), 24);
        measure(1, per);
        check(per == 6, "R9 mon1 carries reference when swapped", per, 6);
        measure(2, per);
        check(per == 21, "R9 mon2 carries M/A when swapped", per, 21);

        // R2: reserved destination is dropped
        send_bits({7'b0, 2'b11, 1'b0, 12'd9, 2'b11}, 24);
        check(cp_mult == 2'd2, "R2 reserved word leaves cp_mult", cp_mult, 2);
        measure(1, per);
        check(per == 6, "R2 reserved word leaves reference ratio", per, 6);

        // R4: short frame
        c_full = ctl_word(12'd6, 1'b0, 2'd1);
        send_bits(c_full, 24);
        send_bits(24'h000002, 2);
        c_part = {c_full[21:0], 2'b10};
        check(cp_mult == c_part[16:15], "R4 cp_mult after short frame", cp_mult, c_part[16:15]);
        measure(2, per);
        check(per == int'(c_part[13:2]), "R4 reference period after short frame", per, int'(c_part[13:2]));

        // R10: power-down
        pwr_dn = 1'b1;
        repeat (3) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mon1 || mon2) highs++;
        end
        check(highs == 0, "R10 monitors low in power-down", highs, 0);
        send_bits(ctl_word(12'd6, 1'b0, 2'd3), 24);
        check(cp_mult == 2'd3, "R10 programming while powered down", cp_mult, 3);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mon1 || mon2) highs++;
        end
        check(highs == 0, "R10 monitors still low after write", highs, 0);
        pwr_dn = 1'b0;
        measure(2, per);
        check(per == 6, "R10 reference resumes after power-down", per, 6);

        // R1: shift clock ignored while enable low, then an empty frame
        c_full = ctl_word(12'd3, 1'b0, 2'd0);
        for (int i = 23; i >= 0; i--) begin
            ser_data = c_full[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        send_bits(24'h0, 0);
        check(cp_mult == 2'd3, "R1 clocks with enable low ignored", cp_mult, 3);
        measure(2, per);
        check(per == 6, "R1 reference ratio kept", per, 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule